// File: doc/BRIEF.md
# Half-Bridge Gate Control and Fault Latch Core

This block is the digital control core of a driver for three half-bridges (parameterisable), each made of one high-side and one low-side switch. It takes a control word from a simple register write port and turns it into one gate-enable line per switch. Each switch has two control bits:

- an on bit, which lets the switch conduct;
- a PWM-select bit, which further gates the switch with a shared PWM pin.

A global run bit forces every switch off when it is cleared. If both switches of one bridge are requested together, both are held off.

The core also latches faults, and the status word shows the result:

- **Thermal shutdown.** A per-stage thermal shutdown flag latches that stage off.
- **Overcurrent.** A per-switch overcurrent flag that stays high for a programmable number of clock cycles latches that switch off, but only while overcurrent shutdown is armed.
- **Common fault bit.** Either kind of fault sets a shared fault bit.
- **Clearing.** A reset-request pulse, carried in the control write, clears all latched faults. Any fault that is still present during that pulse latches again at once.
- **Prewarning.** A thermal prewarning bit follows the OR of the prewarning flags, one cycle late.

Top module: `hb_ctrl_core`

## Requirements
- R1: After reset every gate output is 0, every per-switch status-ok bit is 1, the fault bit is 0 and the prewarning bit is 0. With N=3 the status word is {tp[7], ovl[6], ls_ok[5:3], hs_ok[2:0]}, so after reset it reads 8'h3F.
- R2: A write with wr_en_i loads the control word. With N=3 its fields are: hs_on[2:0], ls_on[5:3], hs_pwm[8:6], ls_pwm[11:9], run[12], oc_arm[13] and srr[14]. A switch's gate is high only when its on bit is 1. When its PWM-select bit is also 1, the gate additionally follows pwm_i.
- R3: While run is 0, all gate outputs are 0. Control writes are still accepted, and a later write with run=1 drives the written pattern.
- R4: If the high-side and low-side on bits of one bridge are both 1, both gates of that bridge are 0. Other bridges are unaffected.
- R5: The status tp bit equals the OR of warn_i as sampled at the previous clock edge.
- R6: When tsd_i[k] is sampled high, both gates of stage k are 0 from the next cycle, both status-ok bits of stage k read 0, and ovl reads 1.
- R7: A stage latched off by thermal shutdown stays off after tsd_i[k] falls, until an srr write arrives while tsd_i[k] is low. The ovl bit stays 1 until an srr write.
- R8: With oc_arm at 0, overcurrent flags change no gate output and never set ovl.
- R9: With oc_arm at 1, a switch whose overcurrent flag is sampled high at D+1 consecutive edges (D = oc_dly_i) is latched off from the following cycle: its status-ok bit is 0 and ovl is 1. A low sample before that restarts the count.
- R10: An srr write clears ovl and all latched switches. The srr bit itself is not stored. A thermal or armed overcurrent condition still present during the srr cycle latches again immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 4*N+3 | Control word |
| pwm_i | input | 1 | Shared PWM pin |
| oc_dly_i | input | DLY_W | Overcurrent shutdown delay in cycles |
| warn_i | input | N | Thermal prewarning flags per stage |
| tsd_i | input | N | Thermal shutdown flags per stage |
| oc_hs_i | input | N | High-side overcurrent flags |
| oc_ls_i | input | N | Low-side overcurrent flags |
| hs_gate_o | output | N | High-side gate enables |
| ls_gate_o | output | N | Low-side gate enables |
| stat_o | output | 2*N+2 | Status word {tp, ovl, ls_ok, hs_ok} |

## Verification
The bench builds the core with N=3, DLY_W=8 and overcurrent shutdown enabled. It programs the delay to 4 and to 0, which places both the D-cycle and D+1-cycle edges of the overcurrent filter within a few cycles, along with the immediate-trip case. With three bridges, a fault or conflict on one stage can be compared against two unaffected neighbours. Using both PWM pin levels shows each select bit both passing and blocking the gate.

// File: rtl/hb_pkg.sv
package hb_pkg;
   function automatic int ctrl_width(input int n);
      return 4 * n + 3;
   endfunction
   function automatic int stat_width(input int n);
      return 2 * n + 2;
   endfunction
endpackage

// File: rtl/hb_oc_filter.sv
module hb_oc_filter #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flag_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             expired_o
);
   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (!flag_i)          cnt_q <= '0;
      else if (cnt_q < dly_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = flag_i && (cnt_q >= dly_i);
endmodule

// File: rtl/hb_stage_fault.sv
module hb_stage_fault (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tsd_i,
   input  logic oc_hs_set_i,
   input  logic oc_ls_set_i,
   input  logic clr_i,
   output logic therm_lat_o,
   output logic hs_lat_o,
   output logic ls_lat_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         therm_lat_o <= 1'b0;
         hs_lat_o    <= 1'b0;
         ls_lat_o    <= 1'b0;
      end else begin
         therm_lat_o <= tsd_i       | (therm_lat_o & ~clr_i);
         hs_lat_o    <= oc_hs_set_i | (hs_lat_o    & ~clr_i);
         ls_lat_o    <= oc_ls_set_i | (ls_lat_o    & ~clr_i);
      end
   end
endmodule

// File: rtl/hb_gate_mux.sv
module hb_gate_mux (
   input  logic hs_on_i,
   input  logic ls_on_i,
   input  logic hs_sel_i,
   input  logic ls_sel_i,
   input  logic pwm_i,
   input  logic run_i,
   input  logic hs_block_i,
   input  logic ls_block_i,
   output logic hs_gate_o,
   output logic ls_gate_o
);
   logic clash, hs_want, ls_want;

   always_comb begin
      clash     = hs_on_i & ls_on_i;
      hs_want   = hs_on_i & (~hs_sel_i | pwm_i);
      ls_want   = ls_on_i & (~ls_sel_i | pwm_i);
      hs_gate_o = hs_want & ~clash & run_i & ~hs_block_i;
      ls_gate_o = ls_want & ~clash & run_i & ~ls_block_i;
   end
endmodule

// File: rtl/hb_ctrl_core.sv
module hb_ctrl_core #(
   parameter int N              = 3,
   parameter int DLY_W          = 8,
   parameter bit OC_SHUTDOWN_EN = 1'b1
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_en_i,
   input  logic [hb_pkg::ctrl_width(N)-1:0]  wr_data_i,
   input  logic                              pwm_i,
   input  logic [DLY_W-1:0]                  oc_dly_i,
   input  logic [N-1:0]                      warn_i,
   input  logic [N-1:0]                      tsd_i,
   input  logic [N-1:0]                      oc_hs_i,
   input  logic [N-1:0]                      oc_ls_i,
   output logic [N-1:0]                      hs_gate_o,
   output logic [N-1:0]                      ls_gate_o,
   output logic [hb_pkg::stat_width(N)-1:0]  stat_o
);
   localparam int CW      = hb_pkg::ctrl_width(N);
   localparam int HS_LO   = 0;
   localparam int LS_LO   = N;
   localparam int HP_LO   = 2 * N;
   localparam int LP_LO   = 3 * N;
   localparam int RUN_B   = 4 * N;
   localparam int ARM_B   = 4 * N + 1;
   localparam int SRR_B   = 4 * N + 2;

   initial begin
      if (N < 1)     $error("hb_ctrl_core: N must be at least 1");
      if (DLY_W < 1) $error("hb_ctrl_core: DLY_W must be at least 1");
   end

   logic [CW-2:0] ctrl_q;
   logic          srr_pulse;
   logic          ovl_q, tp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (wr_en_i) ctrl_q <= wr_data_i[CW-2:0];
   end
   assign srr_pulse = wr_en_i & wr_data_i[SRR_B];

   logic          run, arm;
   logic [N-1:0]  hs_on, ls_on, hs_sel, ls_sel;
   assign hs_on  = ctrl_q[HS_LO +: N];
   assign ls_on  = ctrl_q[LS_LO +: N];
   assign hs_sel = ctrl_q[HP_LO +: N];
   assign ls_sel = ctrl_q[LP_LO +: N];
   assign run    = ctrl_q[RUN_B];
   assign arm    = ctrl_q[ARM_B];

   logic [N-1:0] hs_exp, ls_exp, hs_set, ls_set;
   logic [N-1:0] therm_lat, hs_lat, ls_lat;

   generate
      if (OC_SHUTDOWN_EN) begin : g_oc
         for (genvar i = 0; i < N; i++) begin : g_flt
            hb_oc_filter #(.DLY_W(DLY_W)) u_hs_flt (
               .clk_i(clk_i), .rst_ni(rst_ni), .flag_i(oc_hs_i[i]),
               .dly_i(oc_dly_i), .expired_o(hs_exp[i]));
            hb_oc_filter #(.DLY_W(DLY_W)) u_ls_flt (
               .clk_i(clk_i), .rst_ni(rst_ni), .flag_i(oc_ls_i[i]),
               .dly_i(oc_dly_i), .expired_o(ls_exp[i]));
         end
      end else begin : g_no_oc
         assign hs_exp = '0;
         assign ls_exp = '0;
      end
   endgenerate

   assign hs_set = hs_exp & {N{arm}};
   assign ls_set = ls_exp & {N{arm}};

   for (genvar k = 0; k < N; k++) begin : g_stage
      hb_stage_fault u_fault (
         .clk_i(clk_i), .rst_ni(rst_ni), .tsd_i(tsd_i[k]),
         .oc_hs_set_i(hs_set[k]), .oc_ls_set_i(ls_set[k]), .clr_i(srr_pulse),
         .therm_lat_o(therm_lat[k]), .hs_lat_o(hs_lat[k]), .ls_lat_o(ls_lat[k]));
      hb_gate_mux u_mux (
         .hs_on_i(hs_on[k]), .ls_on_i(ls_on[k]),
         .hs_sel_i(hs_sel[k]), .ls_sel_i(ls_sel[k]),
         .pwm_i(pwm_i), .run_i(run),
         .hs_block_i(therm_lat[k] | hs_lat[k]),
         .ls_block_i(therm_lat[k] | ls_lat[k]),
         .hs_gate_o(hs_gate_o[k]), .ls_gate_o(ls_gate_o[k]));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovl_q <= 1'b0;
         tp_q  <= 1'b0;
      end else begin
         ovl_q <= (|tsd_i) | (|hs_set) | (|ls_set) | (ovl_q & ~srr_pulse);
         tp_q  <= |warn_i;
      end
   end

   assign stat_o = {tp_q, ovl_q, ~(ls_lat | therm_lat), ~(hs_lat | therm_lat)};
endmodule

// File: rtl/hb_ctrl_core_chk.sv
module hb_ctrl_core_chk #(
   parameter int N = 3
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [N-1:0] hs_gate_o,
   input logic [N-1:0] ls_gate_o,
   input logic [2*N+1:0] stat_o,
   input logic [N-1:0] warn_i,
   input logic [N-1:0] tsd_i,
   input logic [N-1:0] oc_hs_i,
   input logic [N-1:0] oc_ls_i,
   input logic         run,
   input logic         arm,
   input logic         srr_pulse
);
   localparam int OVL = 2 * N;
   localparam int TP  = 2 * N + 1;

   a_r3_run_low_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (hs_gate_o == '0 && ls_gate_o == '0));
   a_r4_no_shoot_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_gate_o & ls_gate_o) == '0);
   a_r5_tp_follows_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warn_i != '0) |=> stat_o[TP]);
   a_r6_tsd_sets_ovl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tsd_i != '0) |=> (stat_o[OVL] && (hs_gate_o & $past(tsd_i)) == '0
                         && (ls_gate_o & $past(tsd_i)) == '0));
   a_r7_ovl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o[OVL] && !srr_pulse) |=> stat_o[OVL]);
   a_r8_unarmed_no_ovl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm && !stat_o[OVL] && tsd_i == '0) |=> !stat_o[OVL]);
   a_r10_srr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srr_pulse && tsd_i == '0 && !(arm && (oc_hs_i != '0 || oc_ls_i != '0)))
      |=> !stat_o[OVL]);
endmodule

bind hb_ctrl_core hb_ctrl_core_chk #(.N(N)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o),
   .stat_o(stat_o), .warn_i(warn_i), .tsd_i(tsd_i), .oc_hs_i(oc_hs_i),
   .oc_ls_i(oc_ls_i), .run(run), .arm(arm), .srr_pulse(srr_pulse));

// File: tb/hb_ctrl_core_bench.sv
module hb_ctrl_core_bench;
   localparam int N = 3;
   localparam int DLY_W = 8;

   logic          clk_i = 0;
   logic          rst_ni = 0;
   logic          wr_en_i = 0;
   logic [14:0]   wr_data_i = '0;
   logic          pwm_i = 0;
   logic [7:0]    oc_dly_i = 8'd4;
   logic [2:0]    warn_i = '0, tsd_i = '0, oc_hs_i = '0, oc_ls_i = '0;
   logic [2:0]    hs_gate_o, ls_gate_o;
   logic [7:0]    stat_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk_i = ~clk_i;

   hb_ctrl_core #(.N(N), .DLY_W(DLY_W), .OC_SHUTDOWN_EN(1'b1)) u_hb_ctrl_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .pwm_i(pwm_i), .oc_dly_i(oc_dly_i), .warn_i(warn_i), .tsd_i(tsd_i),
      .oc_hs_i(oc_hs_i), .oc_ls_i(oc_ls_i), .hs_gate_o(hs_gate_o),
      .ls_gate_o(ls_gate_o), .stat_o(stat_o));

   function automatic logic [14:0] cw(input logic [2:0] hs, input logic [2:0] ls,
                                      input logic [2:0] hp, input logic [2:0] lp,
                                      input logic run, input logic arm, input logic srr);
      return {srr, arm, run, lp, hp, ls, hs};
   endfunction

   task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [14:0] d);
      @(negedge clk_i); wr_en_i = 1; wr_data_i = d;
      @(negedge clk_i); wr_en_i = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic t_reset;
      chk("R1 gates", {8'd0, hs_gate_o, ls_gate_o}, 14'd0);
      chk("R1 status", {6'd0, stat_o}, {6'd0, 8'h3F});
   endtask

   task automatic t_gate;
      pwm_i = 0;
      wr(cw(3'b101, 3'b010, 3'b000, 3'b000, 1, 0, 0));
      chk("R2 plain", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b101, 3'b010});
      wr(cw(3'b101, 3'b010, 3'b001, 3'b010, 1, 0, 0));
      chk("R2 pwm low", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b100, 3'b000});
      pwm_i = 1; #1;
      chk("R2 pwm high", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b101, 3'b010});
      pwm_i = 0;
   endtask

   task automatic t_inhibit;
      wr(cw(3'b010, 3'b001, 3'b000, 3'b000, 0, 0, 0));
      chk("R3 run low", {8'd0, hs_gate_o, ls_gate_o}, 14'd0);
      wr(cw(3'b010, 3'b001, 3'b000, 3'b000, 1, 0, 0));
      chk("R3 run high", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b010, 3'b001});
   endtask

   task automatic t_conflict;
      wr(cw(3'b011, 3'b001, 3'b000, 3'b000, 1, 0, 0));
      chk("R4 conflict", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b010, 3'b000});
   endtask

   task automatic t_warn;
      @(negedge clk_i); warn_i = 3'b010;
      @(negedge clk_i);
      chk("R5 tp set", {13'd0, stat_o[7]}, 14'd1);
      warn_i = 3'b000;
      @(negedge clk_i);
      chk("R5 tp clr", {13'd0, stat_o[7]}, 14'd0);
   endtask

   task automatic t_thermal;
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 0, 0));
      tsd_i = 3'b010;
      @(negedge clk_i);
      chk("R6 gates", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b101, 3'b000});
      chk("R6 status", {6'd0, stat_o}, {6'd0, 8'b0110_1101});
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 0, 1));
      chk("R10 relatch", {8'd0, hs_gate_o, stat_o[6], 2'b0}, {8'd0, 3'b101, 1'b1, 2'b0});
      tsd_i = 3'b000;
      cyc(3);
      chk("R7 held", {8'd0, hs_gate_o, stat_o[6], 2'b0}, {8'd0, 3'b101, 1'b1, 2'b0});
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 0, 1));
      chk("R10 clear", {6'd0, hs_gate_o, stat_o[6:2]}, {6'd0, 3'b111, 5'b01111});
   endtask

   task automatic t_oc_unarmed;
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 0, 0));
      oc_hs_i = 3'b001;
      cyc(20);
      chk("R8 gates", {8'd0, hs_gate_o, ls_gate_o}, {8'd0, 3'b111, 3'b000});
      chk("R8 status", {6'd0, stat_o}, {6'd0, 8'h3F});
      oc_hs_i = 3'b000;
      @(negedge clk_i);
   endtask

   task automatic t_oc_armed;
      oc_dly_i = 8'd4;
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 1, 0));
      oc_hs_i = 3'b001; cyc(3);
      oc_hs_i = 3'b000; cyc(1);
      oc_hs_i = 3'b001; cyc(4);
      chk("R9 before expiry", {6'd0, hs_gate_o, stat_o[6], stat_o[3:0]},
          {6'd0, 3'b111, 1'b0, 4'hF});
      cyc(1);
      chk("R9 tripped", {6'd0, hs_gate_o, stat_o[6], stat_o[3:0]},
          {6'd0, 3'b110, 1'b1, 4'b1110});
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 1, 1));
      chk("R10 oc relatch", {6'd0, hs_gate_o, stat_o[6], stat_o[3:0]},
          {6'd0, 3'b110, 1'b1, 4'b1110});
      oc_hs_i = 3'b000; @(negedge clk_i);
      wr(cw(3'b111, 3'b000, 3'b000, 3'b000, 1, 1, 1));
      chk("R10 oc clear", {6'd0, hs_gate_o, stat_o[6], stat_o[3:0]},
          {6'd0, 3'b111, 1'b0, 4'hF});
      oc_dly_i = 8'd0;
      oc_ls_i = 3'b100;
      wr(cw(3'b000, 3'b100, 3'b000, 3'b000, 1, 1, 0));
      chk("R9 zero delay", {6'd0, ls_gate_o, stat_o[6], stat_o[5:2]},
          {6'd0, 3'b000, 1'b1, 4'b0111});
      oc_ls_i = 3'b000;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(2); rst_ni = 1; @(negedge clk_i);
      t_reset();
      t_gate();
      t_inhibit();
      t_conflict();
      t_warn();
      t_thermal();
      t_oc_unarmed();
      t_oc_armed();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule